// File: doc/BRIEF.md
# Five-Stage In-Order Pipelined Processor Core

This core runs a small word-addressed instruction set with eight general registers. Each instruction is 32 bits wide and passes through five stages in order: fetch, decode with register read, execute, memory access and writeback. Edge-triggered registers separate the stages. The core fetches from an instruction-memory read port indexed by the program counter. It reaches data memory through a port with enable and write-enable. A separate read port exposes any register so that state can be inspected after the program stops.

Data hazards are handled in two ways. Results are forwarded from the two stages that follow execute, and the core stalls for one cycle when an instruction needs the value of a load directly ahead of it. Branches are predicted not taken. A taken branch is resolved when it reaches the memory stage, which loads the program counter with the target and discards the three younger instructions. A halt instruction stops the core when it reaches writeback.

Top module: `cpu5_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `imem_addr` is 0, `halted` is 0, `dmem_en` is 0 and every register reads 0.
- R2: Instruction fields are: opcode in bits 24:22, first source A in bits 21:19, second source B in bits 16..18, and a 16-bit offset in bits 15:0 that is sign-extended. Opcodes are 0 add, 1 nand, 2 load, 3 store, 4 branch-if-equal, 6 halt and 7 no-op; code 5 also acts as a no-op. Add and nand write the register named in bits 2:0, and a load writes the register named by field B.
- R3: Add writes A+B and nand writes ~(A&B) to the destination register at writeback.
- R4: Load and store use A+offset as the word address and assert `dmem_en` in the memory stage. A load writes the returned word to its destination. A store asserts `dmem_we` and drives the value of B on `dmem_wdata`.
- R5: An instruction reading a register written by either of the two instructions ahead of it gets the new value without a stall. When both of those instructions write the register, the younger one's result is used.
- R6: An instruction that names, in field A or field B, the destination of a load directly ahead of it is held for exactly one cycle, after which it gets the loaded value.
- R7: Branch-if-equal compares A with B. If they are equal, the next fetch is at PC+1+offset, and the three younger instructions leave no effect on registers or memory. If they differ, execution continues in sequence.
- R8: When a halt reaches writeback, `halted` rises and stays high and `imem_addr` stops changing. No later instruction writes a register or memory.
- R9: `dbg_val` shows the current contents of the register selected by `dbg_sel`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | AW | Instruction word address (program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_en | output | 1 | Data-memory access in this cycle |
| dmem_we | output | 1 | Data-memory write (with `dmem_en`) |
| dmem_addr | output | AW | Data word address |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |
| halted | output | 1 | Core has retired a halt and is frozen |
| dbg_sel | input | 3 | Register index for inspection |
| dbg_val | output | 32 | Contents of the selected register |

## Verification
A wrong forwarding select or a missing load stall leaves a stale value in the destination register. That value shows on `dbg_val` after the halt, and it also reaches memory early when a store uses the bad value, because the store writes in its memory stage. A flush that misses a younger instruction shows up as a store to memory that should never happen, within three cycles of the branch. A wrong redirect either loops forever, which the wait for `halted` catches, or skips work, which leaves a wrong final sum. After the halt, any further movement of `imem_addr` or any memory write shows directly at the ports in the next cycle.

// File: rtl/cpu5_pkg.sv
package cpu5_pkg;

    localparam int DW     = 32;
    localparam int NREG   = 8;
    localparam int RIDX_W = $clog2(NREG);
    localparam int OFF_W  = 16;

    // instruction field positions (behavioural: decode depends on them)
    localparam int OPC_LSB = 22;
    localparam int RA_LSB  = 19;
    localparam int RB_LSB  = 16;
    localparam int RD_LSB  = 0;

    typedef logic [DW-1:0]     word_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_NAND  = 3'd1,
        OP_LOAD  = 3'd2,
        OP_STORE = 3'd3,
        OP_BEQ   = 3'd4,
        OP_RSV   = 3'd5,
        OP_HALT  = 3'd6,
        OP_NOP   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        FW_RF  = 2'd0,
        FW_MEM = 2'd1,
        FW_WB  = 2'd2
    } fwd_e;

    typedef struct packed {
        logic  valid;
        word_t instr;
        word_t pc1;
    } fd_t;

    typedef struct packed {
        logic  valid;
        op_e   op;
        ridx_t ra;
        ridx_t rb;
        ridx_t rd;
        word_t va;
        word_t vb;
        word_t imm;
        word_t pc1;
    } dx_t;

    typedef struct packed {
        logic  valid;
        op_e   op;
        ridx_t rb;
        ridx_t rd;
        word_t res;
        word_t vb;
        word_t target;
        logic  eq;
    } xm_t;

    typedef struct packed {
        logic  valid;
        op_e   op;
        ridx_t rb;
        ridx_t rd;
        word_t res;
        word_t mdata;
    } mw_t;

    function automatic word_t sext(input logic [OFF_W-1:0] v);
        return {{(DW-OFF_W){v[OFF_W-1]}}, v};
    endfunction

    function automatic logic writes_reg(input op_e op);
        return (op == OP_ADD) || (op == OP_NAND) || (op == OP_LOAD);
    endfunction

    // destination: bits 2:0 for ALU ops, field B for a load
    function automatic ridx_t dest_of(input op_e op, input ridx_t rb, input ridx_t rd);
        return (op == OP_LOAD) ? rb : rd;
    endfunction

endpackage

// File: rtl/cpu5_regfile.sv
module cpu5_regfile
    import cpu5_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ridx_t rd_a_idx,
    output word_t rd_a_val,
    input  ridx_t rd_b_idx,
    output word_t rd_b_val,
    input  ridx_t dbg_idx,
    output word_t dbg_out,
    input  logic  wr_en,
    input  ridx_t wr_idx,
    input  word_t wr_val
);

    word_t regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_idx] <= wr_val;
        end
    end

    // a write in this cycle is visible to the decode read in the same cycle
    assign rd_a_val = (wr_en && wr_idx == rd_a_idx) ? wr_val : regs[rd_a_idx];
    assign rd_b_val = (wr_en && wr_idx == rd_b_idx) ? wr_val : regs[rd_b_idx];
    assign dbg_out  = regs[dbg_idx];

endmodule

// File: rtl/cpu5_hazard.sv
module cpu5_hazard
    import cpu5_pkg::*;
(
    input  logic  fd_valid,
    input  ridx_t fd_ra,
    input  ridx_t fd_rb,
    input  logic  dx_valid,
    input  op_e   dx_op,
    input  ridx_t dx_ra,
    input  ridx_t dx_rb,
    input  logic  xm_valid,
    input  op_e   xm_op,
    input  ridx_t xm_dest,
    input  logic  mw_valid,
    input  op_e   mw_op,
    input  ridx_t mw_dest,
    output logic  stall,
    output fwd_e  fwd_a,
    output fwd_e  fwd_b
);

    logic xm_fwd_ok, mw_fwd_ok;

    // a load in the memory stage has no result yet; the stall keeps it apart
    assign xm_fwd_ok = xm_valid && writes_reg(xm_op) && (xm_op != OP_LOAD);
    assign mw_fwd_ok = mw_valid && writes_reg(mw_op);

    function automatic fwd_e pick(input ridx_t src, input logic a_ok, input ridx_t a_d,
                                  input logic b_ok, input ridx_t b_d);
        if (a_ok && a_d == src)      return FW_MEM;
        else if (b_ok && b_d == src) return FW_WB;
        else                         return FW_RF;
    endfunction

    assign fwd_a = pick(dx_ra, xm_fwd_ok, xm_dest, mw_fwd_ok, mw_dest);
    assign fwd_b = pick(dx_rb, xm_fwd_ok, xm_dest, mw_fwd_ok, mw_dest);

    // load destination is field B of the load in execute
    assign stall = dx_valid && (dx_op == OP_LOAD) && fd_valid &&
                   ((dx_rb == fd_ra) || (dx_rb == fd_rb));

endmodule

// File: rtl/cpu5_alu.sv
module cpu5_alu
    import cpu5_pkg::*;
(
    input  op_e   op,
    input  word_t a,
    input  word_t b,
    input  word_t imm,
    output word_t res,
    output logic  eq
);

    word_t rhs;

    assign rhs = (op == OP_LOAD || op == OP_STORE) ? imm : b;
    assign eq  = (a == b);

    always_comb begin
        unique case (op)
            OP_NAND: res = ~(a & rhs);
            default: res = a + rhs;
        endcase
    end

endmodule

// File: rtl/cpu5_core.sv
module cpu5_core
    import cpu5_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic [AW-1:0]     imem_addr,
    input  logic [DW-1:0]     imem_rdata,
    output logic              dmem_en,
    output logic              dmem_we,
    output logic [AW-1:0]     dmem_addr,
    output logic [DW-1:0]     dmem_wdata,
    input  logic [DW-1:0]     dmem_rdata,
    output logic              halted,
    input  logic [RIDX_W-1:0] dbg_sel,
    output logic [DW-1:0]     dbg_val
);

    word_t pc_q;
    fd_t   fd_q;
    dx_t   dx_q;
    xm_t   xm_q;
    mw_t   mw_q;
    logic  halt_q;

    // ---------------- decode fields ----------------
    op_e   id_op;
    ridx_t id_ra, id_rb, id_rd;
    word_t id_va, id_vb;
    logic  unused_hi;

    assign id_op     = op_e'(fd_q.instr[OPC_LSB +: 3]);
    assign id_ra     = fd_q.instr[RA_LSB +: RIDX_W];
    assign id_rb     = fd_q.instr[RB_LSB +: RIDX_W];
    assign id_rd     = fd_q.instr[RD_LSB +: RIDX_W];
    assign unused_hi = ^fd_q.instr[DW-1:OPC_LSB+3];

    // ---------------- writeback ----------------
    logic  wb_we;
    ridx_t wb_idx;
    word_t wb_val;
    logic  halt_now, freeze;

    assign wb_idx   = dest_of(mw_q.op, mw_q.rb, mw_q.rd);
    assign wb_val   = (mw_q.op == OP_LOAD) ? mw_q.mdata : mw_q.res;
    assign wb_we    = mw_q.valid && writes_reg(mw_q.op) && !halt_q;
    assign halt_now = mw_q.valid && (mw_q.op == OP_HALT);
    assign freeze   = halt_q || halt_now;

    cpu5_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .rd_a_idx(id_ra),
        .rd_a_val(id_va),
        .rd_b_idx(id_rb),
        .rd_b_val(id_vb),
        .dbg_idx (dbg_sel),
        .dbg_out (dbg_val),
        .wr_en   (wb_we),
        .wr_idx  (wb_idx),
        .wr_val  (wb_val)
    );

    // ---------------- hazards ----------------
    logic  stall;
    fwd_e  fwd_a, fwd_b;
    ridx_t xm_dest;

    assign xm_dest = dest_of(xm_q.op, xm_q.rb, xm_q.rd);

    cpu5_hazard u_hz (
        .fd_valid(fd_q.valid),
        .fd_ra   (id_ra),
        .fd_rb   (id_rb),
        .dx_valid(dx_q.valid),
        .dx_op   (dx_q.op),
        .dx_ra   (dx_q.ra),
        .dx_rb   (dx_q.rb),
        .xm_valid(xm_q.valid),
        .xm_op   (xm_q.op),
        .xm_dest (xm_dest),
        .mw_valid(mw_q.valid),
        .mw_op   (mw_q.op),
        .mw_dest (wb_idx),
        .stall   (stall),
        .fwd_a   (fwd_a),
        .fwd_b   (fwd_b)
    );

    // ---------------- execute ----------------
    word_t ex_a, ex_b, ex_res;
    logic  ex_eq;

    always_comb begin
        unique case (fwd_a)
            FW_MEM:  ex_a = xm_q.res;
            FW_WB:   ex_a = wb_val;
            default: ex_a = dx_q.va;
        endcase
        unique case (fwd_b)
            FW_MEM:  ex_b = xm_q.res;
            FW_WB:   ex_b = wb_val;
            default: ex_b = dx_q.vb;
        endcase
    end

    cpu5_alu u_alu (
        .op (dx_q.op),
        .a  (ex_a),
        .b  (ex_b),
        .imm(dx_q.imm),
        .res(ex_res),
        .eq (ex_eq)
    );

    // ---------------- memory stage ----------------
    logic redirect, xm_mem;

    assign redirect   = xm_q.valid && (xm_q.op == OP_BEQ) && xm_q.eq;
    assign xm_mem     = xm_q.valid && (xm_q.op == OP_LOAD || xm_q.op == OP_STORE);
    assign dmem_en    = xm_mem && !freeze;
    assign dmem_we    = dmem_en && (xm_q.op == OP_STORE);
    assign dmem_addr  = xm_q.res[AW-1:0];
    assign dmem_wdata = xm_q.vb;

    // ---------------- pipeline registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            fd_q   <= '0;
            dx_q   <= '0;
            xm_q   <= '0;
            mw_q   <= '0;
            halt_q <= 1'b0;
        end else if (freeze) begin
            halt_q <= 1'b1;
        end else begin
            // fetch
            if (redirect) begin
                pc_q       <= xm_q.target;
                fd_q.valid <= 1'b0;
            end else if (!stall) begin
                pc_q  <= pc_q + 1'b1;
                fd_q  <= '{valid: 1'b1, instr: imem_rdata, pc1: pc_q + 1'b1};
            end
            // decode
            if (redirect || stall) begin
                dx_q.valid <= 1'b0;
            end else begin
                dx_q <= '{valid: fd_q.valid, op: id_op, ra: id_ra, rb: id_rb, rd: id_rd,
                          va: id_va, vb: id_vb, imm: sext(fd_q.instr[OFF_W-1:0]),
                          pc1: fd_q.pc1};
            end
            // execute
            if (redirect) begin
                xm_q.valid <= 1'b0;
            end else begin
                xm_q <= '{valid: dx_q.valid, op: dx_q.op, rb: dx_q.rb, rd: dx_q.rd,
                          res: ex_res, vb: ex_b, target: dx_q.pc1 + dx_q.imm, eq: ex_eq};
            end
            // memory
            mw_q <= '{valid: xm_q.valid, op: xm_q.op, rb: xm_q.rb, rd: xm_q.rd,
                      res: xm_q.res, mdata: dmem_rdata};
        end
    end

    assign imem_addr = pc_q[AW-1:0];
    assign halted    = halt_q;

    // plain views of stage occupancy for the checker
    logic fd_v, dx_v, xm_v;
    assign fd_v = fd_q.valid;
    assign dx_v = dx_q.valid;
    assign xm_v = xm_q.valid;

endmodule

// File: rtl/cpu5_core_chk.sv
module cpu5_core_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] imem_addr,
    input logic          halted,
    input logic          dmem_en,
    input logic          dmem_we,
    input logic          stall,
    input logic          redirect,
    input logic          freeze,
    input logic          fd_v,
    input logic          dx_v,
    input logic          xm_v
);

    // R8: once halted, the core stays halted
    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R8: the program counter no longer moves after the halt
    a_r8_pc_frozen: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(imem_addr));

    // R8: no memory traffic while halted
    a_r8_no_mem_access: assert property (@(posedge clk) disable iff (rst)
        halted |-> !dmem_en);

    // R4: a write strobe never appears without the access enable
    a_r4_we_with_en: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> dmem_en);

    // R6: a load-use stall holds the fetch address for one cycle
    a_r6_stall_holds_pc: assert property (@(posedge clk) disable iff (rst)
        (stall && !redirect && !freeze) |=> $stable(imem_addr));

    // R7: a taken branch empties the three younger stages
    a_r7_flush_younger: assert property (@(posedge clk) disable iff (rst)
        (redirect && !freeze) |=> (!fd_v && !dx_v && !xm_v));

endmodule

bind cpu5_core cpu5_core_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .imem_addr(imem_addr),
    .halted   (halted),
    .dmem_en  (dmem_en),
    .dmem_we  (dmem_we),
    .stall    (stall),
    .redirect (redirect),
    .freeze   (freeze),
    .fd_v     (fd_v),
    .dx_v     (dx_v),
    .xm_v     (xm_v)
);

// File: tb/cpu5_core_bench.sv
`timescale 1ns/1ps
module cpu5_core_bench;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] imem_addr;
    logic [31:0]   imem_rdata;
    logic          dmem_en, dmem_we;
    logic [AW-1:0] dmem_addr;
    logic [31:0]   dmem_wdata, dmem_rdata;
    logic          halted;
    logic [2:0]    dbg_sel = '0;
    logic [31:0]   dbg_val;

    always #5 clk = ~clk;

    cpu5_core #(.AW(AW)) u_cpu5_core (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_en(dmem_en), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .halted(halted), .dbg_sel(dbg_sel), .dbg_val(dbg_val)
    );

    // memories
    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    logic        pk_we = 1'b0;
    logic [5:0]  pk_a = '0;
    logic [31:0] pk_d = '0;

    assign imem_rdata = imem[imem_addr[5:0]];
    assign dmem_rdata = dmem[dmem_addr[5:0]];

    always @(posedge clk) begin
        if (pk_we) dmem[pk_a] <= pk_d;
        else if (dmem_en && dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // opcode 24:22, A 21:19, B 18:16, offset/dest 15:0 (R2)
    function automatic logic [31:0] ins(input int op, input int ra, input int rb, input int off);
        return {7'd0, op[2:0], ra[2:0], rb[2:0], off[15:0]};
    endfunction

    task automatic poke(input int a, input logic [31:0] d);
        pk_we = 1'b1; pk_a = a[5:0]; pk_d = d;
        @(posedge clk); #1;
        pk_we = 1'b0;
    endtask

    task automatic reg_rd(input int idx, output logic [31:0] v);
        dbg_sel = idx[2:0];
        #1 v = dbg_val;
    endtask

    task automatic run_to_halt(input string tag);
        int cyc = 0;
        @(negedge clk) rst = 1'b0;
        while (!halted && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        check({tag, " halted"}, {31'd0, halted}, 32'd1);
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0: return "R9 r0";
            1: return "R8 r1 untouched after halt";
            2: return "R4 r2 load";
            3: return "R6 r3 load-use";
            4: return "R3 r4 nand";
            5: return "R5 r5 forwarding";
            6: return "R4 r6 load of stored word";
            default: return "R7 r7 not-taken path";
        endcase
    endfunction

    localparam logic [31:0] EXP1 [8] = '{
        32'd0, 32'd5, 32'd9, 32'd14, 32'hFFFF_FFFB, 32'd9, 32'd9, 32'd18
    };

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [AW-1:0] pc_snap;

        // ---------------- program 1 ----------------
        for (int i = 0; i < 64; i++) imem[i] = ins(7, 0, 0, 0);
        imem[0]  = ins(2, 0, 1, 20);     // lw  r1 <- m[20]
        imem[1]  = ins(2, 0, 2, 21);     // lw  r2 <- m[21]
        imem[2]  = ins(0, 1, 2, 3);      // add r3 = r1+r2  (load-use)
        imem[3]  = ins(1, 3, 1, 4);      // nand r4
        imem[4]  = ins(0, 4, 3, 5);      // add r5 = r4+r3
        imem[5]  = ins(3, 0, 5, 30);     // sw  r5 -> m[30]
        imem[6]  = ins(4, 1, 1, 2);      // beq taken -> 9
        imem[7]  = ins(3, 0, 1, 32);     // flushed store
        imem[8]  = ins(3, 0, 2, 33);     // flushed store
        imem[9]  = ins(2, 0, 6, 30);     // lw  r6 <- m[30]
        imem[10] = ins(4, 6, 1, 5);      // beq not taken
        imem[11] = ins(0, 6, 6, 7);      // add r7 = r6+r6
        imem[12] = ins(6, 0, 0, 0);      // halt
        imem[13] = ins(3, 0, 3, 31);     // must not store
        imem[14] = ins(0, 2, 2, 1);      // must not write r1

        rst = 1'b1;
        poke(20, 32'd5);
        poke(21, 32'd9);
        poke(30, 32'd0);
        poke(31, 32'd0);
        poke(32, 32'd0);
        poke(33, 32'd0);

        // reset state (R1)
        @(negedge clk);
        check("R1 pc at reset", {16'd0, imem_addr}, 32'd0);
        check("R1 halted at reset", {31'd0, halted}, 32'd0);
        check("R1 no memory access at reset", {31'd0, dmem_en}, 32'd0);

        run_to_halt("R8 prog1");

        // table of register expectations, walked through the debug port
        for (int i = 0; i < 8; i++) begin
            reg_rd(i, v);
            check(tag_of(i), v, EXP1[i]);
        end
        check("R4 store of forwarded sum", dmem[30], 32'd9);
        check("R7 flushed store m[32]", dmem[32], 32'd0);
        check("R7 flushed store m[33]", dmem[33], 32'd0);
        check("R8 store after halt m[31]", dmem[31], 32'd0);

        pc_snap = imem_addr;
        repeat (5) @(negedge clk);
        check("R8 pc frozen", {16'd0, imem_addr}, {16'd0, pc_snap});
        check("R8 halted held", {31'd0, halted}, 32'd1);

        // ---------------- reset clears state ----------------
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_rd(3, v);
        check("R1 r3 cleared by reset", v, 32'd0);
        check("R1 halted cleared by reset", {31'd0, halted}, 32'd0);
        check("R1 pc cleared by reset", {16'd0, imem_addr}, 32'd0);

        // ---------------- program 2: counted loop with backward branch ----------------
        for (int i = 0; i < 64; i++) imem[i] = ins(7, 0, 0, 0);
        imem[0] = ins(2, 0, 1, 40);      // r1 = 3
        imem[1] = ins(2, 0, 2, 41);      // r2 = -1
        imem[2] = ins(0, 3, 1, 3);       // r3 += r1
        imem[3] = ins(0, 1, 2, 1);       // r1 += r2
        imem[4] = ins(4, 1, 0, 1);       // r1==0 -> 6
        imem[5] = ins(4, 0, 0, -4);      // back to 2
        imem[6] = ins(3, 0, 3, 43);      // m[43] = r3
        imem[7] = ins(6, 0, 0, 0);       // halt
        imem[8] = ins(5, 0, 0, 0);       // reserved code acts as no-op

        poke(40, 32'd3);
        poke(41, 32'hFFFF_FFFF);
        poke(43, 32'd0);
        run_to_halt("R7 prog2");

        reg_rd(1, v);
        check("R7 loop counter r1", v, 32'd0);
        reg_rd(2, v);
        check("R2 sign of loaded word r2", v, 32'hFFFF_FFFF);
        reg_rd(3, v);
        check("R5 loop sum r3", v, 32'd6);
        check("R4 store after loop m[43]", dmem[43], 32'd6);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule